// File: doc/BRIEF.md
# Center-Spread Modulation Profile Generator

This block produces the digital frequency-offset profile used to spread a clock's energy over a narrow band. It is clocked directly by the reference clock. On every reference cycle it outputs a signed offset word. A downstream fractional divider or phase accumulator adds that word to its nominal increment. Over one modulation period the offset traces a symmetric triangle: it rises from zero to a positive peak, falls through zero to an equal negative peak, and climbs back to zero. The instantaneous frequency therefore swings equally above and below nominal.

A two-bit range code selects how many reference cycles one modulation period lasts: 120, 240, 480 or 720. This ties the modulation rate to the reference frequency. A three-bit spread code selects the total peak-to-peak deviation, from 1.0 % to 4.0 % in 0.5 % steps. Both codes are treated as slow configuration. The block samples them only when the profile passes through zero, so a new setting never causes a frequency step. A pulse marks the first cycle of each period.

Top module: `ssProfileGen`

## Requirements
- R1: A clock edge with `rstN` low sets the phase to 0 and the direction to rising. In the following cycle `freqOffset` is 0 and `profileStart` is 1.
- R2: After reset the block runs with range code 2 (480 cycles) and spread code 2 (peak 328). It keeps these settings until the first zero crossing, whatever `rangeSel` and `spreadSel` hold.
- R3: Range code 0, 1, 2, 3 gives a period of N = 120, 240, 480, 720 reference cycles respectively. With steady settings, successive `profileStart` pulses are exactly N cycles apart.
- R4: The phase c counts reference cycles from 0 to N-1, with Q = N/4. The triangle index t equals c for c ≤ Q, 2Q-c for Q ≤ c ≤ 3Q, and c-4Q above 3Q. The output is `freqOffset` = sign(t)·floor(|t|·S / 65536), where S = ceil(P·65536 / Q).
- R5: The offset is a Q15 fraction of the nominal increment, where 32768 stands for 1.0. Spread code k (0..6) means a total spread of 1.0 % + 0.5 %·k. The peak is P = (k+2)·82 LSB, and the positive and negative extremes both reach exactly P in magnitude.
- R6: Spread code 7 behaves exactly as code 6.
- R7: Two successive offsets never differ by more than ceil(656/30) = 22 LSB.
- R8: The range and spread inputs are sampled only on the edge that leaves phase N-1 (next phase 0) or the edge that leaves phase 2Q-1. On the second of these edges the phase jumps to 2Q' of the new setting, so the falling half continues under that setting.
- R9: `profileStart` is 1 exactly in the cycles where the phase is 0, and the offset is 0 in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Synchronous reset, active low |
| rangeSel | input | 2 | Modulation-rate range code (0..3 selects 120/240/480/720) |
| spreadSel | input | 3 | Total spread code (0..6 gives 1.0 %..4.0 %; 7 acts as 6) |
| freqOffset | output | 16 | Signed Q15 offset relative to the nominal increment |
| profileStart | output | 1 | High in the first cycle of each modulation period |

## Verification
The phase counter and the offset accumulator are the only state. Both outputs decode from those registers with no further register, so the result of any clock edge is visible in the cycle that follows it. A setting change shows no effect until the next zero-crossing edge. The first offset of the new setting then appears one cycle after that edge. The bench keeps a reference phase and setting of its own and advances them at every rising edge using the inputs that edge samples. It compares both outputs at the following falling edge. Targeted points are counted from the reset edge: the default peak 120 cycles later, the switch to a new setting at cycle 241, and the next period start at cycle 300.

// File: rtl/ssProfPkg.sv
package ssProfPkg;

  localparam int RANGE_W    = 2;
  localparam int SPREAD_W   = 3;
  localparam int SPREAD_TOP = 6;

  // strobes from the sequencer to the offset accumulator
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic zeroAcc;
  } stepCtl_t;

  // quarter-period multiplier for each range code
  function automatic int rangeMult(input logic [RANGE_W-1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/ssStepLut.sv
module ssStepLut
  import ssProfPkg::*;
#(
  parameter int QBASE     = 30,
  parameter int PEAK_UNIT = 82,
  parameter int FRAC_W    = 16,
  parameter int ACC_W     = 32
) (
  input  logic [RANGE_W-1:0]  cfgRange,
  input  logic [SPREAD_W-1:0] cfgSpread,
  output logic [ACC_W-1:0]    stepVal
);

  localparam int ENTRIES = 1 << (RANGE_W + SPREAD_W);

  logic [ACC_W-1:0] stepTab [ENTRIES];

  // per-cycle increment, rounded up so the peak lands exactly on P
  for (genvar i = 0; i < ENTRIES; i++) begin : g_step
    localparam int     RC  = i >> SPREAD_W;
    localparam int     KR  = i % (1 << SPREAD_W);
    localparam int     KC  = (KR > SPREAD_TOP) ? SPREAD_TOP : KR;
    localparam longint PK  = longint'((KC + 2) * PEAK_UNIT);
    localparam longint QQ  = longint'(QBASE * rangeMult(RANGE_W'(RC)));
    localparam longint SV  = ((PK << FRAC_W) + QQ - 1) / QQ;
    assign stepTab[i] = ACC_W'(SV);
  end

  assign stepVal = stepTab[{cfgRange, cfgSpread}];

endmodule

// File: rtl/ssProfileCtrl.sv
module ssProfileCtrl
  import ssProfPkg::*;
#(
  parameter int QBASE          = 30,
  parameter int DEFAULT_RANGE  = 2,
  parameter int DEFAULT_SPREAD = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [RANGE_W-1:0]  rangeSel,
  input  logic [SPREAD_W-1:0] spreadSel,
  output logic [RANGE_W-1:0]  cfgRange,
  output logic [SPREAD_W-1:0] cfgSpread,
  output stepCtl_t            ctl,
  output logic                profileStart
);

  localparam int CNT_W = $clog2(4 * QBASE * 6);

  logic [CNT_W-1:0]    phase;
  logic [CNT_W-1:0]    quarterCur;
  logic [CNT_W-1:0]    quarterNew;
  logic [CNT_W-1:0]    halfCur;
  logic [CNT_W-1:0]    lastPh;
  logic                atEnd;
  logic                atMid;
  logic                risingPh;
  logic [SPREAD_W-1:0] spreadClamp;

  always_comb begin
    quarterCur  = CNT_W'(QBASE * rangeMult(cfgRange));
    quarterNew  = CNT_W'(QBASE * rangeMult(rangeSel));
    halfCur     = quarterCur << 1;
    lastPh      = (quarterCur << 2) - CNT_W'(1);
    atEnd       = (phase == lastPh);
    atMid       = (phase == halfCur - CNT_W'(1));
    risingPh    = (phase < quarterCur) || (phase >= halfCur + quarterCur);
    spreadClamp = (spreadSel > SPREAD_W'(SPREAD_TOP)) ? SPREAD_W'(SPREAD_TOP) : spreadSel;
  end

  always_comb begin
    ctl.zeroAcc  = atEnd || atMid;
    ctl.stepUp   = risingPh && !(atEnd || atMid);
    ctl.stepDown = !risingPh && !(atEnd || atMid);
  end

  assign profileStart = (phase == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= '0;
      cfgRange  <= RANGE_W'(DEFAULT_RANGE);
      cfgSpread <= SPREAD_W'(DEFAULT_SPREAD);
    end else if (atEnd) begin
      phase     <= '0;
      cfgRange  <= rangeSel;
      cfgSpread <= spreadClamp;
    end else if (atMid) begin
      phase     <= quarterNew << 1;
      cfgRange  <= rangeSel;
      cfgSpread <= spreadClamp;
    end else begin
      phase <= phase + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ssOffsetPath.sv
module ssOffsetPath
  import ssProfPkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int FRAC_W   = 16,
  parameter int OFFSET_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  stepCtl_t                   ctl,
  input  logic [ACC_W-1:0]           stepVal,
  output logic signed [OFFSET_W-1:0] freqOffset
);

  logic signed [ACC_W-1:0] acc;
  logic [ACC_W-1:0]        absAcc;
  logic [OFFSET_W-1:0]     mag;

  always_ff @(posedge clk) begin
    if (!rstN)             acc <= '0;
    else if (ctl.zeroAcc)  acc <= '0;
    else if (ctl.stepUp)   acc <= acc + $signed(stepVal);
    else if (ctl.stepDown) acc <= acc - $signed(stepVal);
  end

  // sign-magnitude rounding keeps both extremes the same size
  always_comb begin
    absAcc     = acc[ACC_W-1] ? ACC_W'(-acc) : ACC_W'(acc);
    mag        = OFFSET_W'(absAcc >> FRAC_W);
    freqOffset = acc[ACC_W-1] ? -$signed(mag) : $signed(mag);
  end

endmodule

// File: rtl/ssProfileGen.sv
module ssProfileGen
  import ssProfPkg::*;
#(
  parameter int OFFSET_W       = 16,
  parameter int FRAC_W         = 16,
  parameter int ACC_W          = 32,
  parameter int QBASE          = 30,
  parameter int PEAK_UNIT      = 82,
  parameter int DEFAULT_RANGE  = 2,
  parameter int DEFAULT_SPREAD = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 rangeSel,
  input  logic [2:0]                 spreadSel,
  output logic signed [OFFSET_W-1:0] freqOffset,
  output logic                       profileStart
);

  logic [RANGE_W-1:0]  cfgRange;
  logic [SPREAD_W-1:0] cfgSpread;
  logic [ACC_W-1:0]    stepVal;
  stepCtl_t            ctl;

  ssProfileCtrl #(
    .QBASE(QBASE), .DEFAULT_RANGE(DEFAULT_RANGE), .DEFAULT_SPREAD(DEFAULT_SPREAD)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .rangeSel(rangeSel), .spreadSel(spreadSel),
    .cfgRange(cfgRange), .cfgSpread(cfgSpread), .ctl(ctl), .profileStart(profileStart)
  );

  ssStepLut #(
    .QBASE(QBASE), .PEAK_UNIT(PEAK_UNIT), .FRAC_W(FRAC_W), .ACC_W(ACC_W)
  ) lut_i (
    .cfgRange(cfgRange), .cfgSpread(cfgSpread), .stepVal(stepVal)
  );

  ssOffsetPath #(
    .ACC_W(ACC_W), .FRAC_W(FRAC_W), .OFFSET_W(OFFSET_W)
  ) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stepVal(stepVal), .freqOffset(freqOffset)
  );

endmodule

// File: rtl/ssProfileGenChk.sv
module ssProfileGenChk #(
  parameter int OFFSET_W   = 16,
  parameter int QBASE      = 30,
  parameter int PEAK_UNIT  = 82,
  parameter int SPREAD_TOP = 6
) (
  input logic                       clk,
  input logic                       rstN,
  input logic signed [OFFSET_W-1:0] freqOffset,
  input logic                       profileStart
);

  localparam int MAX_PEAK = (SPREAD_TOP + 2) * PEAK_UNIT;
  localparam int MAX_STEP = (MAX_PEAK + QBASE - 1) / QBASE;

  logic seenRst = 1'b0;
  logic armed   = 1'b0;

  always_ff @(posedge clk) begin
    seenRst <= seenRst | !rstN;
    armed   <= seenRst & rstN;
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> (freqOffset == '0 && profileStart));

  assert_start_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    profileStart |-> freqOffset == '0);

  assert_small_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ((int'(freqOffset) - int'($past(freqOffset))) <= MAX_STEP &&
               (int'(freqOffset) - int'($past(freqOffset))) >= -MAX_STEP));

  assert_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (int'(freqOffset) <= MAX_PEAK && int'(freqOffset) >= -MAX_PEAK));

  assert_rise_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(profileStart)) |-> int'(freqOffset) >= 0);

  assert_start_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    profileStart |=> !profileStart);

endmodule

bind ssProfileGen ssProfileGenChk chk_i (
  .clk(clk), .rstN(rstN), .freqOffset(freqOffset), .profileStart(profileStart)
);

// File: tb/ssProfileGen_tb_top.sv
`timescale 1ns/1ps
module ssProfileGen_tb_top;

  logic               clk = 1'b0;
  logic               rstN;
  logic [1:0]         rangeSel;
  logic [2:0]         spreadSel;
  logic signed [15:0] freqOffset;
  logic               profileStart;

  int checks = 0;
  int errors = 0;
  int mC, mR, mK;
  int prevOff;
  bit prevValid = 1'b0;

  localparam int NVEC = 6;
  localparam int VEC_R [NVEC] = '{0, 1, 3, 2, 0, 3};
  localparam int VEC_K [NVEC] = '{0, 3, 6, 1, 7, 0};
  localparam int VEC_P [NVEC] = '{164, 410, 656, 246, 656, 164};

  always #2 clk = ~clk;

  ssProfileGen dut_i (
    .clk(clk), .rstN(rstN), .rangeSel(rangeSel), .spreadSel(spreadSel),
    .freqOffset(freqOffset), .profileStart(profileStart)
  );

  function automatic int quarterOf(input int r);
    case (r)
      0: return 30;
      1: return 60;
      2: return 120;
      default: return 180;
    endcase
  endfunction

  function automatic int expOffset(input int r, input int k, input int c);
    int q = quarterOf(r);
    longint pk = longint'((k + 2) * 82);
    longint s = ((pk * 65536) + q - 1) / q;
    int t;
    longint mag;
    if (c <= q) t = c;
    else if (c <= 3 * q) t = 2 * q - c;
    else t = c - 4 * q;
    mag = (longint'(t < 0 ? -t : t) * s) >> 16;
    return (t < 0) ? -int'(mag) : int'(mag);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model advances on each rising edge, compare at the falling edge
  task automatic tick();
    int q, off, d;
    @(posedge clk);
    if (!rstN) begin
      mC = 0; mR = 2; mK = 2;
    end else begin
      q = quarterOf(mR);
      if (mC == 4 * q - 1 || mC == 2 * q - 1) begin
        mC = (mC == 4 * q - 1) ? 0 : 2 * quarterOf(int'(rangeSel));
        mR = int'(rangeSel);
        mK = (spreadSel > 3'd6) ? 6 : int'(spreadSel);
      end else begin
        mC = mC + 1;
      end
    end
    @(negedge clk);
    off = int'(freqOffset);
    check(off == expOffset(mR, mK, mC), "R4/R8 profile value", off, expOffset(mR, mK, mC));
    check(profileStart == (mC == 0), "R9 start pulse", int'(profileStart), int'(mC == 0));
    if (prevValid && rstN) begin
      d = off - prevOff;
      if (d < 0) d = -d;
      check(d <= 22, "R7 step size", d, 22);
    end
    prevOff   = off;
    prevValid = rstN;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s, len, mx, mn;
    rstN = 1'b0; rangeSel = 2'd2; spreadSel = 3'd2;
    mC = 0; mR = 2; mK = 2; prevOff = 0;
    repeat (3) tick();
    check(freqOffset == 0, "R1 reset offset", int'(freqOffset), 0);
    check(profileStart == 1'b1, "R1 reset start", int'(profileStart), 1);
    rstN = 1'b1;

    // table walk: settle on each setting, then measure one clean period
    for (int v = 0; v < NVEC; v++) begin
      rangeSel  = 2'(VEC_R[v]);
      spreadSel = 3'(VEC_K[v]);
      s = 0;
      while (s < 2) begin
        tick();
        if (profileStart) s++;
      end
      len = 0; mx = 0; mn = 0;
      do begin
        tick();
        len++;
        if (int'(freqOffset) > mx) mx = int'(freqOffset);
        if (int'(freqOffset) < mn) mn = int'(freqOffset);
      end while (!profileStart);
      check(len == 4 * quarterOf(VEC_R[v]), "R3 period length", len, 4 * quarterOf(VEC_R[v]));
      check(mx == VEC_P[v], "R5/R6 positive peak", mx, VEC_P[v]);
      check(mn == -VEC_P[v], "R5/R6 negative peak", mn, -VEC_P[v]);
    end

    // R2 and R8: new inputs wait for the first zero crossing after reset
    rangeSel = 2'd0; spreadSel = 3'd6;
    rstN = 1'b0;
    tick();
    check(freqOffset == 0 && profileStart, "R1 reset mid-run", int'(freqOffset), 0);
    rstN = 1'b1;
    repeat (120) tick();
    check(freqOffset == 328, "R2 default peak", int'(freqOffset), 328);
    repeat (121) tick();
    check(freqOffset == -21, "R8 new setting after mid crossing", int'(freqOffset), -21);
    repeat (58) tick();
    check(profileStart == 1'b0, "R8 no start before 300", int'(profileStart), 0);
    tick();
    check(profileStart == 1'b1, "R8 start at cycle 300", int'(profileStart), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule